// File: doc/BRIEF.md
# Standby Rail Sequencer

This block brings a chipset's standby well up and takes it down again in a fixed, timed order. It drives the primary rail enable, the 5 V enable, the suspend acknowledge, the deep-well power-OK, the resume reset, the hand-off of sleep control to the chipset, and the two power-OK outputs. Every wait between two steps is counted in microseconds. A tick generator derived from the system clock produces the microsecond count, and it restarts at the start of each wait, so every wait has an exact cycle length.

After reset the block waits for the real-time-clock supply to settle and then rests in deep-S5. A validated power-button request (`up_req`) starts the power-up order, which ends in S5. In S5, the system power-good input controls the chipset and system power-OK outputs. A rising power-down acknowledge with the S4 sleep signal low, or an explicit `down_req`, runs the power-down order back to deep-S5. A rising acknowledge with the S4 sleep signal high means S3 entry, and the rails stay on. `busy` is high whenever a sequence is running, and requests that arrive during that time are dropped.

Top module: `standby_rail_sequencer`

## Requirements
- R1: While `rst_n` is low, all eight rail and power-OK outputs are 0 (resume reset asserted, suspend acknowledge asserted) and `busy` is 1.
- R2: After reset is released, `busy` falls on the (T_RTC_US*CLK_PER_US+1)-th rising clock edge and every output stays 0.
- R3: `up_req` sampled high in deep-S5 starts the power-up order. On that edge `rail_prim_en` rises. T_PRIM_US*P+1 cycles later `rail_5v_en` and `sus_ack_n` rise together. T_5V_US*P+1 cycles after that `dwell_pok` rises, and one cycle later `rsm_rst_n` rises. T_RSM_US*P+1 cycles later `handoff_en` rises, and T_HAND_US*P+1 cycles after that `busy` falls (P = CLK_PER_US).
- R4: `up_req` in S5 has no effect on any output or on `busy`.
- R5: `up_req`, `down_req` and acknowledge edges that arrive while `busy` is high are ignored, and the running order keeps its exact timing.
- R6: In S5, a rising `sys_pg` raises `chip_pok` on the sampling edge and raises `sys_pok` T_SYSOK_US*P+1 cycles later.
- R7: A falling `sys_pg` drops `sys_pok` on the sampling edge and `chip_pok` one cycle later. If the fall arrives during the power-OK wait, `sys_pok` never rises.
- R8: A rising `pwrdn_ack` while `s4_sleep_n` is 1 (S3 entry) changes no output.
- R9: A rising `pwrdn_ack` with `s4_sleep_n` 0 in S5 runs the power-down order, one output per cycle from the sampling edge: `sys_pok`, `chip_pok`, `handoff_en`, `rsm_rst_n`, then `rail_5v_en`. After a short wait `rail_prim_en` drops, `dwell_pok` drops one cycle later, and `busy` falls after a second short wait. `sus_ack_n` is left unchanged. The block returns to deep-S5 and accepts `up_req` again.
- R10: `down_req` sampled in S5 runs the same power-down order as R9.
- R11: In deep-S5, `pwrdn_ack`, `down_req` and `sys_pg` activity changes no output.
- R12: Waits given in nanoseconds round up to whole microsecond ticks. The default 400 ns short wait lasts one tick, so it spans CLK_PER_US+1 cycles between the two output steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Validated power-button request to bring up S5 |
| down_req | input | 1 | Request to leave S5 and power the well down |
| sys_pg | input | 1 | Platform system power-good |
| pwrdn_ack | input | 1 | Suspend power-down acknowledge from the chipset |
| s4_sleep_n | input | 1 | S4 sleep signal, high when not in S4 |
| rail_prim_en | output | 1 | Primary rail enable |
| rail_5v_en | output | 1 | 5 V rail enable |
| sus_ack_n | output | 1 | Suspend acknowledge, active low |
| dwell_pok | output | 1 | Deep-well power-OK |
| rsm_rst_n | output | 1 | Resume reset, active low |
| handoff_en | output | 1 | Lets the chipset drive its sleep controls |
| chip_pok | output | 1 | Chipset power-OK |
| sys_pok | output | 1 | System power-OK |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach is a power-good fall during the system power-OK wait. The ports show that abort only as a `chip_pok` drop with no `sys_pok` pulse before it. The bench raises `sys_pg` in S5, drops it a few cycles later, well inside the wait, and confirms that the rise time recorded for `sys_pok` has not moved. A second hard case is a set of requests that land in the middle of a running order. The bench injects `up_req`, `down_req` and an acknowledge together a few cycles into power-up, then checks that every later step keeps its exact arithmetic gap.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [4:0] {
      ST_RTC,
      ST_DS5,
      UP_PRIM,
      UP_5V,
      UP_DWOK,
      UP_RSM,
      UP_HAND,
      ST_S5,
      PG_WAIT,
      PG_ON,
      PG_DROP_SYS,
      PG_DROP_CHIP,
      DN_SYS,
      DN_CHIP,
      DN_HAND,
      DN_RSM,
      DN_5V,
      DN_PRIM,
      DN_DWOK
   } rail_st_e;

   typedef struct packed {
      logic sys_pok;
      logic chip_pok;
      logic handoff_en;
      logic rsm_rst_n;
      logic dwell_pok;
      logic sus_ack_n;
      logic rail_5v_en;
      logic rail_prim_en;
   } rail_out_t;

   function automatic int unsigned ns_to_us_ceil(input int unsigned ns);
      return (ns + 999) / 1000;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rail_us_tick.sv
module rail_us_tick #(
   parameter int unsigned CLK_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("rail_us_tick: CLK_PER_US must be at least 1");
      end

      if (CLK_PER_US == 1) begin : g_every_cycle
         assign tick = 1'b1;
         logic unused_pins;
         assign unused_pins = ^{clk, rst_n, clr};
      end else begin : g_divider
         localparam int unsigned PW = $clog2(CLK_PER_US);
         localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);
         logic [PW-1:0] pre;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pre <= '0;
            else if (clr)        pre <= '0;
            else if (pre == LAST) pre <= '0;
            else                 pre <= pre + 1'b1;
         end

         assign tick = (pre == LAST);
      end
   endgenerate
endmodule

// File: rtl/rail_wait_timer.sv
module rail_wait_timer #(
   parameter int unsigned TW      = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [TW-1:0] ld_val,
   input  logic          tick,
   output logic          done
);
   generate
      if (TW < 1) begin : g_bad_width
         $error("rail_wait_timer: TW must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= TW'(RST_VAL);
      else if (ld)                 cnt <= ld_val;
      else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/rail_edge_det.sv
module rail_edge_det #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rail_edge_det: N must be at least 1");
      end

      for (genvar i = 0; i < N; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= din[i];
         end
         assign rise[i] = din[i] & ~q;
         assign fall[i] = ~din[i] & q;
      end
   endgenerate
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
   import rail_seq_pkg::*;
#(
   parameter int unsigned TW         = 8,
   parameter int unsigned W_PRIM     = 1,
   parameter int unsigned W_5V       = 1,
   parameter int unsigned W_RSM      = 1,
   parameter int unsigned W_HAND     = 1,
   parameter int unsigned W_SYSOK    = 1,
   parameter int unsigned W_SHORT    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up_req,
   input  logic          down_req,
   input  logic          ack_rise,
   input  logic          s4_n,
   input  logic          pg_rise,
   input  logic          pg_fall,
   input  logic          tmr_done,
   output logic          tmr_ld,
   output logic [TW-1:0] tmr_val,
   output rail_out_t     outs,
   output logic          busy
);
   rail_st_e st, nxt;
   logic     go;
   logic     drop_req;

   // Step that follows a timed or single-cycle step in a fixed order.
   function automatic rail_st_e succ(input rail_st_e s);
      case (s)
         ST_RTC:       return ST_DS5;
         UP_PRIM:      return UP_5V;
         UP_5V:        return UP_DWOK;
         UP_DWOK:      return UP_RSM;
         UP_RSM:       return UP_HAND;
         UP_HAND:      return ST_S5;
         PG_WAIT:      return PG_ON;
         PG_DROP_SYS:  return PG_DROP_CHIP;
         PG_DROP_CHIP: return ST_S5;
         DN_SYS:       return DN_CHIP;
         DN_CHIP:      return DN_HAND;
         DN_HAND:      return DN_RSM;
         DN_RSM:       return DN_5V;
         DN_5V:        return DN_PRIM;
         DN_PRIM:      return DN_DWOK;
         DN_DWOK:      return ST_DS5;
         default:      return s;
      endcase
   endfunction

   // Output change made on entry to a step.
   function automatic rail_out_t enter(input rail_out_t o, input rail_st_e s);
      rail_out_t r;
      r = o;
      case (s)
         UP_PRIM:                   r.rail_prim_en = 1'b1;
         UP_5V: begin
                                    r.rail_5v_en   = 1'b1;
                                    r.sus_ack_n    = 1'b1;
         end
         UP_DWOK:                   r.dwell_pok    = 1'b1;
         UP_RSM:                    r.rsm_rst_n    = 1'b1;
         UP_HAND:                   r.handoff_en   = 1'b1;
         PG_WAIT:                   r.chip_pok     = 1'b1;
         PG_ON:                     r.sys_pok      = 1'b1;
         PG_DROP_SYS, DN_SYS:       r.sys_pok      = 1'b0;
         PG_DROP_CHIP, DN_CHIP:     r.chip_pok     = 1'b0;
         DN_HAND:                   r.handoff_en   = 1'b0;
         DN_RSM:                    r.rsm_rst_n    = 1'b0;
         DN_5V:                     r.rail_5v_en   = 1'b0;
         DN_PRIM:                   r.rail_prim_en = 1'b0;
         DN_DWOK:                   r.dwell_pok    = 1'b0;
         default:                   r = o;
      endcase
      return r;
   endfunction

   // Wait, in ticks, that a step holds before moving on.
   function automatic logic [TW-1:0] hold_of(input rail_st_e s);
      case (s)
         UP_PRIM:          return TW'(W_PRIM);
         UP_5V:            return TW'(W_5V);
         UP_RSM:           return TW'(W_RSM);
         UP_HAND:          return TW'(W_HAND);
         PG_WAIT:          return TW'(W_SYSOK);
         DN_5V, DN_DWOK:   return TW'(W_SHORT);
         default:          return '0;
      endcase
   endfunction

   assign drop_req = down_req | (ack_rise & ~s4_n);

   always_comb begin
      nxt = st;
      go  = 1'b0;
      case (st)
         ST_DS5: begin
            if (up_req) begin
               nxt = UP_PRIM;
               go  = 1'b1;
            end
         end
         ST_S5: begin
            if (drop_req) begin
               nxt = DN_SYS;
               go  = 1'b1;
            end else if (pg_rise) begin
               nxt = PG_WAIT;
               go  = 1'b1;
            end
         end
         PG_ON: begin
            if (drop_req) begin
               nxt = DN_SYS;
               go  = 1'b1;
            end else if (pg_fall) begin
               nxt = PG_DROP_SYS;
               go  = 1'b1;
            end
         end
         PG_WAIT: begin
            if (pg_fall) begin
               nxt = PG_DROP_SYS;
               go  = 1'b1;
            end else if (tmr_done) begin
               nxt = PG_ON;
               go  = 1'b1;
            end
         end
         default: begin
            if (tmr_done) begin
               nxt = succ(st);
               go  = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_RTC;
         outs <= '0;
      end else if (go) begin
         st   <= nxt;
         outs <= enter(outs, nxt);
      end
   end

   assign tmr_ld  = go;
   assign tmr_val = hold_of(nxt);
   assign busy    = !(st == ST_DS5 || st == ST_S5 || st == PG_ON);
endmodule

// File: rtl/standby_rail_sequencer.sv
module standby_rail_sequencer
   import rail_seq_pkg::*;
#(
   parameter int unsigned CLK_PER_US  = 100,
   parameter int unsigned T_RTC_US    = 9000,
   parameter int unsigned T_PRIM_US   = 200,
   parameter int unsigned T_5V_US     = 10000,
   parameter int unsigned T_RSM_US    = 95000,
   parameter int unsigned T_HAND_US   = 200000,
   parameter int unsigned T_SYSOK_US  = 10000,
   parameter int unsigned T_SHORT_NS  = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_req,
   input  logic down_req,
   input  logic sys_pg,
   input  logic pwrdn_ack,
   input  logic s4_sleep_n,
   output logic rail_prim_en,
   output logic rail_5v_en,
   output logic sus_ack_n,
   output logic dwell_pok,
   output logic rsm_rst_n,
   output logic handoff_en,
   output logic chip_pok,
   output logic sys_pok,
   output logic busy
);
   localparam int unsigned T_SHORT_US = ns_to_us_ceil(T_SHORT_NS);
   localparam int unsigned MAXW = max2(max2(max2(T_RTC_US, T_PRIM_US), max2(T_5V_US, T_RSM_US)),
                                       max2(max2(T_HAND_US, T_SYSOK_US), T_SHORT_US));
   localparam int unsigned TW = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

   generate
      if (TW > 32) begin : g_bad_span
         $error("standby_rail_sequencer: wait span too wide");
      end
   endgenerate

   logic          tick;
   logic          tmr_ld;
   logic [TW-1:0] tmr_val;
   logic          tmr_done;
   logic [1:0]    ev_rise, ev_fall;
   rail_out_t     outs;

   rail_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_ld),
      .tick  (tick)
   );

   rail_wait_timer #(.TW(TW), .RST_VAL(T_RTC_US)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (tmr_ld),
      .ld_val (tmr_val),
      .tick   (tick),
      .done   (tmr_done)
   );

   rail_edge_det #(.N(2)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({pwrdn_ack, sys_pg}),
      .rise  (ev_rise),
      .fall  (ev_fall)
   );

   rail_seq_fsm #(
      .TW      (TW),
      .W_PRIM  (T_PRIM_US),
      .W_5V    (T_5V_US),
      .W_RSM   (T_RSM_US),
      .W_HAND  (T_HAND_US),
      .W_SYSOK (T_SYSOK_US),
      .W_SHORT (T_SHORT_US)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_req   (up_req),
      .down_req (down_req),
      .ack_rise (ev_rise[1]),
      .s4_n     (s4_sleep_n),
      .pg_rise  (ev_rise[0]),
      .pg_fall  (ev_fall[0]),
      .tmr_done (tmr_done),
      .tmr_ld   (tmr_ld),
      .tmr_val  (tmr_val),
      .outs     (outs),
      .busy     (busy)
   );

   logic unused_fall;
   assign unused_fall = ev_fall[1];

   assign rail_prim_en = outs.rail_prim_en;
   assign rail_5v_en   = outs.rail_5v_en;
   assign sus_ack_n    = outs.sus_ack_n;
   assign dwell_pok    = outs.dwell_pok;
   assign rsm_rst_n    = outs.rsm_rst_n;
   assign handoff_en   = outs.handoff_en;
   assign chip_pok     = outs.chip_pok;
   assign sys_pok      = outs.sys_pok;
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic rail_prim_en,
   input logic rail_5v_en,
   input logic dwell_pok,
   input logic rsm_rst_n,
   input logic handoff_en,
   input logic chip_pok,
   input logic sys_pok,
   input logic busy
);
   // R3
   v5_needs_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rail_5v_en |-> rail_prim_en);

   // R3
   rsm_needs_dwok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsm_rst_n |-> dwell_pok);

   // R3
   hand_needs_rsm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      handoff_en |-> rsm_rst_n);

   // R6
   sysok_needs_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_pok |-> chip_pok);

   // R7
   chip_drop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chip_pok) |-> (!sys_pok && $past(!sys_pok)));

   // R5
   prim_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_prim_en) |-> busy);

   // R9
   hand_drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(handoff_en) |-> busy);
endmodule

bind standby_rail_sequencer rail_seq_chk u_chk (.*);

// File: tb/tb_standby_rail_sequencer.sv
module tb_standby_rail_sequencer;
   localparam int P      = 2;
   localparam int T_RTC  = 5;
   localparam int T_PRIM = 3;
   localparam int T_5V   = 4;
   localparam int T_RSM  = 6;
   localparam int T_HAND = 7;
   localparam int T_SYS  = 5;
   localparam int T_SNS  = 400;

   localparam int G_RTC   = T_RTC * P + 1;
   localparam int G_PRIM  = T_PRIM * P + 1;
   localparam int G_5V    = T_5V * P + 1;
   localparam int G_RSM   = T_RSM * P + 1;
   localparam int G_HAND  = T_HAND * P + 1;
   localparam int G_SYS   = T_SYS * P + 1;
   localparam int G_SHORT = ((T_SNS + 999) / 1000) * P + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_req = 1'b0, down_req = 1'b0, sys_pg = 1'b0, pwrdn_ack = 1'b0, s4_sleep_n = 1'b1;
   logic rail_prim_en, rail_5v_en, sus_ack_n, dwell_pok, rsm_rst_n, handoff_en, chip_pok, sys_pok, busy;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int t_rise [9];
   int t_fall [9];
   logic [8:0] prev;
   bit finished = 1'b0;

   standby_rail_sequencer #(
      .CLK_PER_US(P), .T_RTC_US(T_RTC), .T_PRIM_US(T_PRIM), .T_5V_US(T_5V),
      .T_RSM_US(T_RSM), .T_HAND_US(T_HAND), .T_SYSOK_US(T_SYS), .T_SHORT_NS(T_SNS)
   ) dut (.*);

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [8:0] allv();
      return {busy, sys_pok, chip_pok, handoff_en, rsm_rst_n, dwell_pok, sus_ack_n, rail_5v_en, rail_prim_en};
   endfunction

   always @(negedge clk) begin
      logic [8:0] cur;
      cur = allv();
      if (rst_n) begin
         for (int k = 0; k < 9; k++) begin
            if (cur[k] && !prev[k]) t_rise[k] = cyc;
            if (!cur[k] && prev[k]) t_fall[k] = cyc;
         end
      end
      prev = cur;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         if (!busy) break;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic power_up(input bit noise, input bit first);
      int u;
      @(negedge clk); u = cyc; up_req = 1'b1;
      @(negedge clk); up_req = 1'b0;
      if (noise) begin
         // R5: requests during power-up
         repeat (3) @(negedge clk);
         up_req = 1'b1; down_req = 1'b1; pwrdn_ack = 1'b1; s4_sleep_n = 1'b0;
         @(negedge clk);
         up_req = 1'b0; down_req = 1'b0; pwrdn_ack = 1'b0; s4_sleep_n = 1'b1;
      end
      wait_idle();
      chk("R3 prim rise", t_rise[0], u + 1);
      chk("R3 5V rise", t_rise[1], t_rise[0] + G_PRIM);
      if (first) chk("R3 sus ack release", t_rise[2], t_rise[1]);
      chk("R3 deep-well ok rise", t_rise[3], t_rise[1] + G_5V);
      chk("R3 resume reset release", t_rise[4], t_rise[3] + 1);
      chk(noise ? "R5 hand-off timing" : "R3 hand-off rise", t_rise[5], t_rise[4] + G_RSM);
      chk(noise ? "R5 busy end" : "R3 busy end", t_fall[8], t_rise[5] + G_HAND);
      chk("R3 final outputs", int'(allv()), 9'h03F);
   endtask

   task automatic check_down(input int a, input bit from_on, input string tag);
      if (from_on) begin
         chk({tag, " sys drop"}, t_fall[7], a + 1);
         chk({tag, " chip drop"}, t_fall[6], a + 2);
      end
      chk({tag, " hand-off drop"}, t_fall[5], a + 3);
      chk({tag, " resume reset"}, t_fall[4], a + 4);
      chk({tag, " 5V drop"}, t_fall[1], a + 5);
      chk("R12 short wait before prim drop", t_fall[0], t_fall[1] + G_SHORT);
      chk({tag, " deep-well drop"}, t_fall[3], t_fall[0] + 1);
      chk("R12 short wait before idle", t_fall[8], t_fall[3] + G_SHORT);
      chk({tag, " final outputs"}, int'(allv()), 9'h004);
   endtask

   initial begin
      int rel, g, f, a, d, saved;
      logic [8:0] snap;
      // R1
      repeat (4) @(negedge clk);
      chk("R1 reset outputs", int'(allv()), 9'h100);
      rel = cyc; rst_n = 1'b1;
      wait_idle();
      // R2
      chk("R2 initial wait", t_fall[8], rel + G_RTC);
      chk("R2 outputs idle", int'(allv()), 9'h000);

      // R11: events in deep-S5
      s4_sleep_n = 1'b0; pwrdn_ack = 1'b1; down_req = 1'b1; sys_pg = 1'b1;
      @(negedge clk); pwrdn_ack = 1'b0; down_req = 1'b0; s4_sleep_n = 1'b1;
      repeat (6) @(negedge clk); sys_pg = 1'b0;
      repeat (6) @(negedge clk);
      chk("R11 deep-S5 ignores events", int'(allv()), 9'h000);

      power_up(1'b0, 1'b1);

      // R4
      snap = allv();
      @(negedge clk); up_req = 1'b1; @(negedge clk); up_req = 1'b0;
      repeat (10) @(negedge clk);
      chk("R4 up_req in S5", int'(allv()), int'(snap));

      // R8
      s4_sleep_n = 1'b1;
      @(negedge clk); pwrdn_ack = 1'b1; @(negedge clk); pwrdn_ack = 1'b0;
      repeat (10) @(negedge clk);
      chk("R8 S3 entry keeps rails", int'(allv()), int'(snap));

      // R6
      @(negedge clk); g = cyc; sys_pg = 1'b1;
      repeat (G_SYS + 5) @(negedge clk);
      chk("R6 chip ok rise", t_rise[6], g + 1);
      chk("R6 sys ok rise", t_rise[7], t_rise[6] + G_SYS);
      chk("R6 outputs", int'(allv()), 9'h0FF);

      // R7
      @(negedge clk); f = cyc; sys_pg = 1'b0;
      repeat (5) @(negedge clk);
      chk("R7 sys ok drop", t_fall[7], f + 1);
      chk("R7 chip ok drop", t_fall[6], f + 2);

      // R7 abort inside the power-OK wait
      saved = t_rise[7];
      @(negedge clk); sys_pg = 1'b1;
      repeat (3) @(negedge clk); f = cyc; sys_pg = 1'b0;
      repeat (G_SYS + 5) @(negedge clk);
      chk("R7 abort chip drop", t_fall[6], f + 2);
      chk("R7 abort no sys ok", t_rise[7], saved);
      chk("R7 abort outputs", int'(allv()), 9'h03F);

      // R9 from full power
      @(negedge clk); sys_pg = 1'b1;
      repeat (G_SYS + 5) @(negedge clk);
      s4_sleep_n = 1'b0;
      @(negedge clk); a = cyc; pwrdn_ack = 1'b1;
      @(negedge clk); pwrdn_ack = 1'b0;
      wait_idle();
      s4_sleep_n = 1'b1; sys_pg = 1'b0;
      check_down(a, 1'b1, "R9");

      // R5 and R9 return path
      power_up(1'b1, 1'b0);

      // R10
      @(negedge clk); d = cyc; down_req = 1'b1;
      @(negedge clk); down_req = 1'b0;
      wait_idle();
      check_down(d, 1'b0, "R10");

      power_up(1'b0, 1'b0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule